// File: doc/BRIEF.md
# PCI Bus Master Transfer Sequencer

This block is the initiator half of a 32-bit PCI interface. An internal DMA engine hands it one memory request at a time: direction, single or burst, start address, word count and byte enables. The sequencer requests the bus, waits for a grant while the bus is idle, drives the address phase with a fixed command for the access kind, then runs data phases until the words are moved or the target or the arbiter ends the transfer.

Every request produces exactly one response: done, retry (the target disconnected with words left, which the requester re-issues), master abort (no target claimed the cycle, which is fatal and locks the block until cleared) or target abort (error, not locking). Loss of grant during a burst is absorbed inside the block: it finishes the current data phase, gives up the bus, re-arbitrates and resumes from the next address. All bus control signals at the ports are active-high logical values; pad inversion and tri-state drivers sit outside.

Top module: `pci_master_seq`

## Requirements
- R1: In the address phase `cbe_o` carries the command: single read 4'h6, single write 4'h7, burst read 4'hE, burst write 4'h7.
- R2: A burst drives `ad_o[1:0]` = 0 in its address phase (start address rounded down to a word) and `cbe_o` = 4'hF in every data phase; a single access drives the requested byte enables in its data phase.
- R3: `bus_req_o` stays high from acceptance until `bus_gnt_i` is sampled high with `frame_i` and `irdy_i` both low; the address phase follows only such a cycle.
- R4: A single request of N words runs N separate transactions, each with one data phase, with `frame_o` low between them, and ends in one done response.
- R5: If `devsel_i` is not seen by the 4th data-phase cycle after the address phase, the transfer ends with response code 2 (master abort), `fatal_o` goes high and `req_ready_o` stays low until `fatal_clr_i` is pulsed.
- R6: `stop_i` with `devsel_i` and without `trdy_i` ends the transfer with response code 1 (retry), reporting the untransferred word count and the next address.
- R7: `stop_i` with `devsel_i` dropped after `devsel_i` was seen ends the transfer with response code 3 (target abort); the block is not locked.
- R8: If `bus_gnt_i` falls while `frame_o` is high, the current data phase is the last of that transaction; the block re-arbitrates, continues at the next address and gives one response (code 0) at the end.
- R9: Address and remaining count advance (+4, −1) only on cycles where `beat_o` is high (`irdy_o` and `trdy_i` with `devsel_i`); wait states leave `beat_addr_o` unchanged.
- R10: After reset `bus_req_o`, `frame_o`, `irdy_o` and `ad_oe_o` are low and `req_ready_o` is high.
- R11: A response with code 0 reports zero words left and the address one word past the last transferred word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle and not locked; request taken when both high |
| req_write_i | input | 1 | 1 = memory write, 0 = memory read |
| req_burst_i | input | 1 | 1 = burst, 0 = one single transaction per word |
| req_addr_i | input | ADDR_W | Start byte address |
| req_words_i | input | LEN_W | Word count, at least 1 |
| req_be_i | input | 4 | Byte enables for single accesses (1 = byte used) |
| wdata_i | input | 32 | Write word for the address on `beat_addr_o` |
| beat_o | output | 1 | A data word moves this cycle |
| beat_addr_o | output | ADDR_W | Address of the current data word |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_code_o | output | 2 | 0 done, 1 retry, 2 master abort, 3 target abort |
| rsp_left_o | output | LEN_W | Words not transferred |
| rsp_addr_o | output | ADDR_W | Next untransferred address |
| fatal_o | output | 1 | Locked after master abort |
| fatal_clr_i | input | 1 | Clears the lock |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| frame_i | input | 1 | Bus FRAME as seen from other masters |
| irdy_i | input | 1 | Bus IRDY as seen from other masters |
| frame_o | output | 1 | FRAME driven by this master |
| irdy_o | output | 1 | IRDY driven by this master |
| devsel_i | input | 1 | Target claimed the cycle |
| trdy_i | input | 1 | Target ready |
| stop_i | input | 1 | Target requests termination |
| ad_o | output | 32 | Address / write data |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| cbe_o | output | 4 | Command in address phase, byte enables in data phase |

## Verification
A corrupted address or count register shows up on the first later beat as a gap in `beat_addr_o`, and at the latest in the response address one cycle after the transfer ends. A wrong final-phase flag shows as `frame_o` rising again inside a transaction or a preempted burst that resumes at the wrong word, visible at the next address phase. A devsel counter that is off by one turns the slowest legal target into a master abort, or lets a missing target hang, within five cycles of the address phase.

// File: rtl/pcim_pkg.sv
package pcim_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_ARB,
      S_ADDR,
      S_DATA,
      S_TURN
   } pcim_state_e;

   typedef enum logic [1:0] {
      RSP_DONE   = 2'd0,
      RSP_RETRY  = 2'd1,
      RSP_MABORT = 2'd2,
      RSP_TABORT = 2'd3
   } pcim_rsp_e;

   localparam logic [3:0] CMD_MEM_RD      = 4'h6;
   localparam logic [3:0] CMD_MEM_WR      = 4'h7;
   localparam logic [3:0] CMD_MEM_RD_LINE = 4'hE;
endpackage

// File: rtl/pcim_track.sv
module pcim_track #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              align,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_words,
   input  logic              beat,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LEN_W-1:0]  left_q,
   output logic              last_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load) begin
         addr_q <= align ? {load_addr[ADDR_W-1:2], 2'b00} : load_addr;
         left_q <= load_words;
      end else if (beat) begin
         addr_q <= addr_q + STEP;
         left_q <= left_q - 1'b1;
      end
   end

   assign last_o = (left_q == LEN_W'(1));

   // R9: a word never moves once the count is exhausted
   a_r9_no_beat_past_end : assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (left_q != '0));
endmodule

// File: rtl/pcim_dvwatch.sv
module pcim_dvwatch #(
   parameter int WAIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic active,
   input  logic devsel,
   output logic seen_o,
   output logic timeout_o
);
   localparam int CW = $clog2(WAIT + 1);

   logic [CW-1:0] cnt_q;
   logic          seen_q;

   initial begin
      assert (WAIT >= 1) else $error("pcim_dvwatch: WAIT must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (active && !seen_q) begin
         if (devsel) seen_q <= 1'b1;
         else        cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign seen_o    = seen_q;
   assign timeout_o = active && !seen_q && !devsel && (cnt_q == CW'(WAIT - 1));

   // R5: the wait counter never runs past the claim window
   a_r5_window_bound : assert property (@(posedge clk) disable iff (!rst_n)
      (active && !seen_q) |-> (cnt_q < CW'(WAIT)));
endmodule

// File: rtl/pci_master_seq.sv
module pci_master_seq
   import pcim_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int LEN_W         = 8,
   parameter int DEVSEL_WAIT   = 4,
   parameter bit BURST_RD_LINE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic              req_burst_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [LEN_W-1:0]  req_words_i,
   input  logic [3:0]        req_be_i,
   input  logic [31:0]       wdata_i,
   output logic              beat_o,
   output logic [ADDR_W-1:0] beat_addr_o,
   output logic              rsp_valid_o,
   output logic [1:0]        rsp_code_o,
   output logic [LEN_W-1:0]  rsp_left_o,
   output logic [ADDR_W-1:0] rsp_addr_o,
   output logic              fatal_o,
   input  logic              fatal_clr_i,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   input  logic              frame_i,
   input  logic              irdy_i,
   output logic              frame_o,
   output logic              irdy_o,
   input  logic              devsel_i,
   input  logic              trdy_i,
   input  logic              stop_i,
   output logic [31:0]       ad_o,
   output logic              ad_oe_o,
   output logic [3:0]        cbe_o
);
   initial begin
      assert (ADDR_W >= 3 && ADDR_W <= 32) else $error("pci_master_seq: ADDR_W out of range");
      assert (LEN_W >= 1) else $error("pci_master_seq: LEN_W must be positive");
   end

   pcim_state_e st_q, st_d;
   logic        write_q, burst_q, final_q, cont_q, fatal_q;
   logic [3:0]  be_q;
   logic        rsp_set, rsp_valid_q;
   pcim_rsp_e   rsp_d, rsp_code_q;
   logic [3:0]  burst_rd_cmd, cmd;

   logic              accept, in_data, beat, final_now;
   logic              mab, tab, disc, seen, last;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;

   generate
      if (BURST_RD_LINE) begin : g_rd_line
         assign burst_rd_cmd = CMD_MEM_RD_LINE;
      end else begin : g_rd_plain
         assign burst_rd_cmd = CMD_MEM_RD;
      end
   endgenerate

   assign cmd = write_q ? CMD_MEM_WR : (burst_q ? burst_rd_cmd : CMD_MEM_RD);

   assign accept    = req_valid_i && req_ready_o;
   assign in_data   = (st_q == S_DATA);
   assign beat      = in_data && trdy_i && devsel_i;
   assign final_now = final_q || !burst_q || last || !bus_gnt_i;
   assign tab       = in_data && stop_i && !devsel_i && seen;
   assign disc      = in_data && stop_i && devsel_i;

   pcim_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .align      (req_burst_i),
      .load_addr  (req_addr_i),
      .load_words (req_words_i),
      .beat       (beat),
      .addr_q     (addr_q),
      .left_q     (left_q),
      .last_o     (last)
   );

   pcim_dvwatch #(.WAIT(DEVSEL_WAIT)) u_dvwatch (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (st_q == S_ADDR),
      .active    (in_data),
      .devsel    (devsel_i),
      .seen_o    (seen),
      .timeout_o (mab)
   );

   always_comb begin
      st_d    = st_q;
      rsp_set = 1'b0;
      rsp_d   = RSP_DONE;
      case (st_q)
         S_IDLE: if (accept) st_d = S_ARB;
         S_ARB:  if (bus_gnt_i && !frame_i && !irdy_i) st_d = S_ADDR;
         S_ADDR: st_d = S_DATA;
         S_DATA: begin
            if (mab) begin
               st_d = S_TURN; rsp_set = 1'b1; rsp_d = RSP_MABORT;
            end else if (tab) begin
               st_d = S_TURN; rsp_set = 1'b1; rsp_d = RSP_TABORT;
            end else if (beat && last) begin
               st_d = S_TURN; rsp_set = 1'b1; rsp_d = RSP_DONE;
            end else if (disc) begin
               st_d = S_TURN; rsp_set = 1'b1; rsp_d = RSP_RETRY;
            end else if (beat && final_now) begin
               st_d = S_TURN;
            end
         end
         S_TURN: st_d = cont_q ? S_ARB : S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= S_IDLE;
         write_q     <= 1'b0;
         burst_q     <= 1'b0;
         be_q        <= '0;
         final_q     <= 1'b0;
         cont_q      <= 1'b0;
         fatal_q     <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_code_q  <= RSP_DONE;
      end else begin
         st_q        <= st_d;
         rsp_valid_q <= rsp_set;
         if (rsp_set) rsp_code_q <= rsp_d;
         if (accept) begin
            write_q <= req_write_i;
            burst_q <= req_burst_i;
            be_q    <= req_be_i;
         end
         if (st_q == S_ADDR) final_q <= 1'b0;
         else if (in_data)   final_q <= final_now;
         if (in_data) cont_q <= (st_d == S_TURN) && !rsp_set;
         if (mab)              fatal_q <= 1'b1;
         else if (fatal_clr_i) fatal_q <= 1'b0;
      end
   end

   assign req_ready_o = (st_q == S_IDLE) && !fatal_q;
   assign bus_req_o   = (st_q == S_ARB) || (st_q == S_ADDR) || in_data;
   assign frame_o     = (st_q == S_ADDR) || (in_data && !final_now);
   assign irdy_o      = in_data;
   assign ad_oe_o     = (st_q == S_ADDR) || (in_data && write_q);
   assign ad_o        = (st_q == S_ADDR) ? 32'(addr_q) :
                        (in_data && write_q) ? wdata_i : 32'h0;
   assign cbe_o       = (st_q == S_ADDR) ? cmd :
                        in_data ? (burst_q ? 4'hF : be_q) : 4'h0;
   assign beat_o      = beat;
   assign beat_addr_o = addr_q;
   assign rsp_valid_o = rsp_valid_q;
   assign rsp_code_o  = rsp_code_q;
   assign rsp_left_o  = left_q;
   assign rsp_addr_o  = addr_q;
   assign fatal_o     = fatal_q;

   // R3: an address phase only follows a grant sampled on an idle bus
   a_r3_addr_after_idle_grant : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_o) |-> $past(bus_gnt_i && !frame_i && !irdy_i));
   // R8: once the final phase is signalled, FRAME does not come back in that transaction
   a_r8_final_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !frame_o) |=> !frame_o);
   // R9: each moved word advances the address by one word
   a_r9_addr_step : assert property (@(posedge clk) disable iff (!rst_n)
      beat_o |=> (beat_addr_o == $past(beat_addr_o) + ADDR_W'(4)));
   // R9: wait states leave the address alone
   a_r9_wait_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !beat_o) |=> $stable(beat_addr_o));
   // R2: burst address phase is word aligned
   a_r2_burst_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(frame_o) && burst_q) |-> (ad_o[1:0] == 2'b00));
   // R1: writes always carry the memory write command
   a_r1_write_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(frame_o) && write_q) |-> (cbe_o == CMD_MEM_WR));
   // R5: a master abort response leaves the block refusing requests
   a_r5_locked : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_code_o == 2'd2 && !fatal_clr_i) |=> !req_ready_o);
endmodule

// File: tb/tb_pci_master_seq.sv
`timescale 1ns/1ps
module tb_pci_master_seq;
   localparam int AW = 32;
   localparam int LW = 8;
   localparam logic [31:0] PAT = 32'hA5C3_0F1E;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          req_valid_i = 1'b0, req_ready_o;
   logic          req_write_i = 1'b0, req_burst_i = 1'b0;
   logic [AW-1:0] req_addr_i = '0;
   logic [LW-1:0] req_words_i = '0;
   logic [3:0]    req_be_i = '0;
   logic [31:0]   wdata_i;
   logic          beat_o;
   logic [AW-1:0] beat_addr_o, rsp_addr_o;
   logic          rsp_valid_o;
   logic [1:0]    rsp_code_o;
   logic [LW-1:0] rsp_left_o;
   logic          fatal_o, fatal_clr_i = 1'b0;
   logic          bus_req_o, bus_gnt_i = 1'b0;
   logic          frame_i = 1'b0, irdy_i = 1'b0;
   logic          frame_o, irdy_o;
   logic          devsel_i = 1'b0, trdy_i = 1'b0, stop_i = 1'b0;
   logic [31:0]   ad_o;
   logic          ad_oe_o;
   logic [3:0]    cbe_o;

   assign wdata_i = beat_addr_o ^ PAT;

   pci_master_seq dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
      .req_write_i(req_write_i), .req_burst_i(req_burst_i),
      .req_addr_i(req_addr_i), .req_words_i(req_words_i), .req_be_i(req_be_i),
      .wdata_i(wdata_i), .beat_o(beat_o), .beat_addr_o(beat_addr_o),
      .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o),
      .rsp_left_o(rsp_left_o), .rsp_addr_o(rsp_addr_o),
      .fatal_o(fatal_o), .fatal_clr_i(fatal_clr_i),
      .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
      .frame_i(frame_i), .irdy_i(irdy_i),
      .frame_o(frame_o), .irdy_o(irdy_o),
      .devsel_i(devsel_i), .trdy_i(trdy_i), .stop_i(stop_i),
      .ad_o(ad_o), .ad_oe_o(ad_oe_o), .cbe_o(cbe_o)
   );

   int n_tests = 0, n_fail = 0, n_frames = 0, n_rsp = 0;
   // target and arbiter model settings: 0 normal, 1 disconnect after t_k words, 2 target abort, 3 no claim
   int t_lat = 1, t_wait = 0, t_mode = 0, t_k = 0;
   int cyc = 0, beats = 0, tot_beats = 0, pre_cnt = 0;
   bit pre_arm = 1'b0;

   logic [31:0] exp_q[$];
   int          rq_code[$], rq_left[$];
   logic [31:0] rq_addr[$];
   logic [3:0]  exp_cmd, exp_be;
   bit          exp_wr, fr_prev = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // target and arbiter model, driven away from the active edge
   always @(negedge clk) begin
      logic dv, tr, sp;
      dv = 1'b0; tr = 1'b0; sp = 1'b0;
      if (!rst_n) begin
         cyc = 0; beats = 0;
         bus_gnt_i <= 1'b0;
      end else begin
         if (irdy_o) begin
            cyc++;
            case (t_mode)
               0, 1: if (cyc >= t_lat) begin
                  dv = 1'b1;
                  if (t_mode == 1 && beats == t_k) sp = 1'b1;
                  else if (((cyc - t_lat) % (t_wait + 1)) == t_wait) tr = 1'b1;
               end
               2: begin
                  if (cyc == t_lat) dv = 1'b1;
                  else if (cyc == t_lat + 1) sp = 1'b1;
               end
               default: ;
            endcase
            if (tr) begin beats++; tot_beats++; end
         end else begin
            cyc = 0; beats = 0;
         end
         devsel_i <= dv; trdy_i <= tr; stop_i <= sp;
         if (pre_arm && tot_beats == 2) begin pre_cnt = 3; pre_arm = 1'b0; end
         if (pre_cnt > 0) begin bus_gnt_i <= 1'b0; pre_cnt--; end
         else bus_gnt_i <= bus_req_o;
      end
   end

   // monitor: compares the design's output against the scoreboard queues
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (frame_o && !fr_prev) begin
            n_frames++;
            chk(cbe_o == exp_cmd, "R1 command", {28'h0, cbe_o}, {28'h0, exp_cmd});
            if (exp_q.size() > 0)
               chk(ad_o == exp_q[0], "R2 address phase", ad_o, exp_q[0]);
         end
         fr_prev = frame_o;
         if (beat_o) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected word", beat_addr_o, 32'h0);
            else begin
               chk(beat_addr_o == exp_q[0], "R9 word address", beat_addr_o, exp_q[0]);
               chk(cbe_o == exp_be, "R2 byte enables", {28'h0, cbe_o}, {28'h0, exp_be});
               if (exp_wr) chk(ad_o == (exp_q[0] ^ PAT), "R9 write data", ad_o, exp_q[0] ^ PAT);
               void'(exp_q.pop_front());
            end
         end
         if (rsp_valid_o) begin
            n_rsp++;
            if (rq_code.size() == 0) chk(1'b0, "R11 unexpected response", {30'h0, rsp_code_o}, 32'h0);
            else begin
               chk(rsp_code_o == rq_code[0][1:0], "R11 response code", {30'h0, rsp_code_o}, rq_code[0]);
               chk(rsp_left_o == rq_left[0][LW-1:0], "R11 words left", {24'h0, rsp_left_o}, rq_left[0]);
               chk(rsp_addr_o == rq_addr[0], "R11 next address", rsp_addr_o, rq_addr[0]);
               void'(rq_code.pop_front()); void'(rq_left.pop_front()); void'(rq_addr.pop_front());
            end
         end
      end
   end

   // driver: pushes expectations, issues one request, waits for its response
   task automatic issue(input bit wr, input bit bs, input logic [31:0] a, input int words,
                        input logic [3:0] be, input int nbeats, input int code,
                        input int left, input logic [31:0] raddr, input string tag);
      logic [31:0] base;
      int r0, lim;
      base = bs ? {a[31:2], 2'b00} : a;
      for (int i = 0; i < nbeats; i++) exp_q.push_back(base + 32'(4 * i));
      rq_code.push_back(code); rq_left.push_back(left); rq_addr.push_back(raddr);
      exp_cmd = wr ? 4'h7 : (bs ? 4'hE : 4'h6);
      exp_be  = bs ? 4'hF : be;
      exp_wr  = wr;
      lim = 0;
      while (!req_ready_o && lim < 2000) begin @(negedge clk); lim++; end
      r0 = n_rsp;
      req_write_i = wr; req_burst_i = bs; req_addr_i = a;
      req_words_i = LW'(words); req_be_i = be; req_valid_i = 1'b1;
      @(negedge clk);
      req_valid_i = 1'b0;
      lim = 0;
      while (n_rsp == r0 && lim < 3000) begin @(negedge clk); lim++; end
      chk(n_rsp != r0, {tag, " response arrived"}, 32'(n_rsp), 32'(r0 + 1));
      @(negedge clk);
      chk(exp_q.size() == 0, {tag, " all words moved"}, 32'(exp_q.size()), 32'h0);
      exp_q.delete();
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd >= 100000) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int f0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(bus_req_o == 1'b0, "R10 bus_req", {31'h0, bus_req_o}, 32'h0);
      chk(frame_o == 1'b0, "R10 frame", {31'h0, frame_o}, 32'h0);
      chk(irdy_o == 1'b0, "R10 irdy", {31'h0, irdy_o}, 32'h0);
      chk(ad_oe_o == 1'b0, "R10 ad_oe", {31'h0, ad_oe_o}, 32'h0);
      chk(req_ready_o == 1'b1, "R10 ready", {31'h0, req_ready_o}, 32'h1);

      // R1 R2 R11: burst write
      t_lat = 1; t_wait = 0; t_mode = 0;
      issue(1, 1, 32'h1000, 4, 4'h0, 4, 0, 0, 32'h1010, "R11 burst write");
      // R1 R2 R9: burst read, unaligned start, slow claim, wait states
      t_lat = 3; t_wait = 2;
      issue(0, 1, 32'h2002, 3, 4'h0, 3, 0, 0, 32'h200C, "R9 burst read waits");
      // R1 R2: single read with partial byte enables
      t_lat = 2; t_wait = 1;
      issue(0, 0, 32'h3000, 1, 4'b0011, 1, 0, 0, 32'h3004, "R2 single read");
      // R4: single write of three words
      t_lat = 1; t_wait = 0;
      f0 = n_frames;
      issue(1, 0, 32'h4000, 3, 4'b1100, 3, 0, 0, 32'h400C, "R4 single write");
      chk(n_frames - f0 == 3, "R4 one transaction per word", 32'(n_frames - f0), 32'd3);

      // R5 boundary: claim in the 4th data cycle is still accepted
      t_lat = 4;
      issue(0, 0, 32'h5100, 1, 4'hF, 1, 0, 0, 32'h5104, "R5 late claim");
      chk(fatal_o == 1'b0, "R5 late claim no lock", {31'h0, fatal_o}, 32'h0);

      // R5: nobody claims
      t_mode = 3;
      issue(0, 1, 32'h5000, 2, 4'h0, 0, 2, 2, 32'h5000, "R5 master abort");
      repeat (3) @(negedge clk);
      chk(req_ready_o == 1'b0, "R5 locked", {31'h0, req_ready_o}, 32'h0);
      chk(fatal_o == 1'b1, "R5 fatal", {31'h0, fatal_o}, 32'h1);
      f0 = n_frames;
      req_valid_i = 1'b1; @(negedge clk); req_valid_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(n_frames == f0, "R5 no transfer while locked", 32'(n_frames), 32'(f0));
      fatal_clr_i = 1'b1; @(negedge clk); fatal_clr_i = 1'b0;
      chk(req_ready_o == 1'b1, "R5 cleared", {31'h0, req_ready_o}, 32'h1);

      // R6: disconnect without data after two words
      t_mode = 1; t_k = 2; t_lat = 1;
      issue(1, 1, 32'h6000, 5, 4'h0, 2, 1, 3, 32'h6008, "R6 disconnect");

      // R7: target abort
      t_mode = 2; t_lat = 2;
      issue(0, 1, 32'h7000, 4, 4'h0, 0, 3, 4, 32'h7000, "R7 target abort");
      repeat (2) @(negedge clk);
      chk(req_ready_o == 1'b1 && fatal_o == 1'b0, "R7 not locked", {30'h0, req_ready_o, fatal_o}, 32'h2);

      // R8: grant removed mid-burst
      t_mode = 0; t_lat = 1; t_wait = 0;
      tot_beats = 0; pre_arm = 1'b1;
      f0 = n_frames;
      issue(1, 1, 32'h8000, 6, 4'h0, 6, 0, 0, 32'h8018, "R8 preemption");
      chk(n_frames - f0 >= 2, "R8 re-arbitrated", 32'(n_frames - f0), 32'd2);

      // R3: bus busy with another master while granted
      frame_i = 1'b1; irdy_i = 1'b1;
      f0 = n_frames;
      fork
         issue(0, 0, 32'h9000, 1, 4'hF, 1, 0, 0, 32'h9004, "R3 idle bus");
         begin
            repeat (5) @(negedge clk);
            chk(bus_req_o == 1'b1, "R3 request held", {31'h0, bus_req_o}, 32'h1);
            chk(n_frames == f0, "R3 no address phase on busy bus", 32'(n_frames), 32'(f0));
            frame_i = 1'b0; irdy_i = 1'b0;
         end
      join

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule